// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block gathers outgoing frame data from a circular list of transmit descriptors held in system memory. Each descriptor is two 32-bit words. The first word holds a byte count in its low half and a set of flags in its high half. The second word holds the address of the data buffer. The host loads a ring start address, sets the controller enable and then pulses a kick. The walker then works through the ring. It fetches each ready descriptor and streams the buffer bytes out in ascending address order. It joins the buffers of consecutive descriptors into one frame until it meets a descriptor flagged as the end of a frame. Each consumed descriptor is written back with its ready flag cleared, and a one-cycle event pulse reports it.

One kick drains the ring. The walk ends at the first descriptor that is not ready, or after a fixed number of descriptors, whichever comes first. The pointer is left at the point where the walk ended, so the next kick resumes there. A frame that grows past the maximum size is cut at that size and flagged as babbling. The memory port is a plain word port: read data returns one cycle after a read strobe, and writes complete at once.

Top module: `txr_engine`

## Requirements
- R1: A kick pulse starts a walk (tx_active rises on the next cycle) only when ctrl_en is high and no walk is running. A kick while ctrl_en is low, or during a walk, has no effect.
- R2: Descriptor word 0 carries the byte count in bits 15:0, ready in bit 31, wrap in bit 29 and last in bit 27. Word 1 is the buffer address. If a fetched descriptor has ready clear, the walk stops, tx_active falls and cur_ptr stays on that descriptor.
- R3: Buffer bytes are emitted on fb_data, one per fb_valid cycle, in ascending address order. Each byte is taken from the little-endian lane of its memory word. Buffers of consecutive descriptors form one frame, ended by ev_txf after its final byte. The frame length then restarts at zero, and it also restarts at zero on each kick.
- R4: When adding a descriptor's count would exceed MAX_FRAME bytes, only the bytes up to MAX_FRAME are emitted, and ev_babt pulses together with that descriptor's completion event.
- R5: Each consumed descriptor's word 0 is written back at its own address with bit 31 cleared and all other bits unchanged. ev_txb pulses for a descriptor without last, and ev_txf pulses for one with last; the two never pulse together.
- R6: After a descriptor with wrap set, the pointer becomes the ring start. Otherwise it advances by 8 bytes.
- R7: A single kick consumes at most MAX_DESC descriptors, and then tx_active falls with cur_ptr on the next unconsumed descriptor.
- R8: While ctrl_en is low, tx_active is 0 on the next cycle and cur_ptr is reloaded from the ring start, abandoning any walk in progress without a write-back.
- R9: A ring start write clears address bits 2:0 when enh_mode is 1 and bits 1:0 when it is 0. When no walk is running, the same write also loads cur_ptr.
- R10: A memory read strobe and write strobe are never high in the same cycle, and the block consumes read data on the cycle after its read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable |
| enh_mode | input | 1 | 1 selects 8-byte ring start alignment, 0 selects 4-byte |
| base_wr | input | 1 | Ring start write strobe |
| base_wdata | input | ADDR_W | Ring start write value |
| kick | input | 1 | Start-walk pulse |
| tx_active | output | 1 | A walk is in progress |
| cur_ptr | output | ADDR_W | Address of the current descriptor |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |
| fb_valid | output | 1 | Frame byte valid |
| fb_data | output | 8 | Frame byte |
| ev_txb | output | 1 | Pulse: a non-last descriptor was consumed |
| ev_txf | output | 1 | Pulse: a frame was completed |
| ev_babt | output | 1 | Pulse: a frame was truncated at MAX_FRAME |

## Verification
The checker tests on every cycle that the read and write strobes never overlap, and that every write-back carries a cleared ready bit. It also tests that the two completion events are exclusive and that truncation is only flagged on a completion. It further tests that frame bytes appear only during a walk, that an accepted kick raises tx_active, that disabling leaves the pointer at the ring start, and that the descriptor count stays within its cap. Only the bench scenarios can show the byte content and order of each frame, the write-back values, pointer positions after wrap, stop and cap, the truncation length, and the fact that ignored kicks leave the walk unchanged.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_D0, S_D0W, S_D1, S_D1W, S_BRQ, S_BW, S_WB
  } txr_state_e;

  localparam int READY_BIT  = 31;
  localparam int WRAP_BIT   = 29;
  localparam int LAST_BIT   = 27;
  localparam int DESC_BYTES = 8;

  function automatic logic [7:0] byte_lane(input logic [31:0] word, input logic [1:0] lane);
    logic [31:0] sh;
    sh = word >> {lane, 3'b000};
    return sh[7:0];
  endfunction
endpackage

// File: rtl/txr_base_reg.sv
module txr_base_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              enh,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_nxt,
  output logic [ADDR_W-1:0] base_q
);
  always_comb begin
    base_nxt = wdata;
    base_nxt[1:0] = 2'b00;
    if (enh) base_nxt[2] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  base_q <= '0;
    else if (wr) base_q <= base_nxt;
  end
endmodule

// File: rtl/txr_clip.sv
module txr_clip #(
  parameter int MAX_FRAME = 2047,
  parameter int LEN_W     = 16,
  localparam int FILL_W   = $clog2(MAX_FRAME + 1)
) (
  input  logic [FILL_W-1:0] fill,
  input  logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  take,
  output logic              over
);
  function automatic int room_left(input int f);
    return MAX_FRAME - f;
  endfunction

  always_comb begin
    over = (int'(len) > room_left(int'(fill)));
    take = over ? LEN_W'(room_left(int'(fill))) : len;
  end
endmodule

// File: rtl/txr_walk_cnt.sv
module txr_walk_cnt #(
  parameter int MAX_DESC = 1024,
  localparam int CNT_W   = $clog2(MAX_DESC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             final_slot
);
  assign final_slot = (cnt == CNT_W'(MAX_DESC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2047,
  parameter int MAX_DESC  = 1024,
  localparam int LEN_W    = 16,
  localparam int FILL_W   = $clog2(MAX_FRAME + 1),
  localparam int CNT_W    = $clog2(MAX_DESC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              enh_mode,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              kick,
  output logic              tx_active,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              fb_valid,
  output logic [7:0]        fb_data,
  output logic              ev_txb,
  output logic              ev_txf,
  output logic              ev_babt
);
  txr_state_e        state;
  logic [ADDR_W-1:0] base_q, base_nxt, baddr;
  logic [31:0]       w0;
  logic [FILL_W-1:0] fill;
  logic [LEN_W-1:0]  take, rem, tk_q;
  logic              over, over_q;
  logic [CNT_W-1:0]  desc_cnt;
  logic              final_slot;

  // named internal events
  logic kick_go, desc_idle, desc_done, is_last;
  assign kick_go   = kick && ctrl_en && (state == S_IDLE);
  assign desc_idle = (state == S_D0W) && !mem_rdata[READY_BIT];
  assign desc_done = ctrl_en && (state == S_WB);
  assign is_last   = w0[LAST_BIT];

  txr_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .wr(base_wr), .enh(enh_mode),
    .wdata(base_wdata), .base_nxt(base_nxt), .base_q(base_q)
  );

  txr_clip #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) u_clip (
    .fill(fill), .len(w0[LEN_W-1:0]), .take(take), .over(over)
  );

  txr_walk_cnt #(.MAX_DESC(MAX_DESC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(kick_go), .inc(desc_done),
    .cnt(desc_cnt), .final_slot(final_slot)
  );

  function automatic logic [FILL_W-1:0] fill_add(input logic [FILL_W-1:0] f, input logic [LEN_W-1:0] t);
    return FILL_W'(int'(f) + int'(t));
  endfunction

  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = w0;
    mem_wdata[READY_BIT] = 1'b0;
    if (ctrl_en) begin
      unique case (state)
        S_D0:  mem_rd = 1'b1;
        S_D1:  begin mem_rd = 1'b1; mem_addr = cur_ptr + ADDR_W'(4); end
        S_BRQ: begin mem_rd = 1'b1; mem_addr = {baddr[ADDR_W-1:2], 2'b00}; end
        S_WB:  mem_wr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tx_active <= 1'b0; cur_ptr <= '0;
      w0 <= '0; baddr <= '0; fill <= '0; rem <= '0; tk_q <= '0; over_q <= 1'b0;
      fb_valid <= 1'b0; fb_data <= '0;
      ev_txb <= 1'b0; ev_txf <= 1'b0; ev_babt <= 1'b0;
    end else begin
      fb_valid <= 1'b0;
      ev_txb   <= 1'b0;
      ev_txf   <= 1'b0;
      ev_babt  <= 1'b0;
      if (!ctrl_en) begin
        state     <= S_IDLE;
        tx_active <= 1'b0;
        cur_ptr   <= base_wr ? base_nxt : base_q;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (base_wr) cur_ptr <= base_nxt;
            if (kick_go) begin
              state     <= S_D0;
              tx_active <= 1'b1;
              fill      <= '0;
            end
          end
          S_D0:  state <= S_D0W;
          S_D0W: begin
            w0 <= mem_rdata;
            if (desc_idle) begin
              state     <= S_IDLE;
              tx_active <= 1'b0;
            end else begin
              state <= S_D1;
            end
          end
          S_D1:  state <= S_D1W;
          S_D1W: begin
            baddr  <= mem_rdata;
            rem    <= take;
            tk_q   <= take;
            over_q <= over;
            state  <= (take == '0) ? S_WB : S_BRQ;
          end
          S_BRQ: state <= S_BW;
          S_BW: begin
            fb_valid <= 1'b1;
            fb_data  <= byte_lane(mem_rdata, baddr[1:0]);
            baddr    <= baddr + 1'b1;
            rem      <= rem - 1'b1;
            state    <= (rem == LEN_W'(1)) ? S_WB : S_BRQ;
          end
          S_WB: begin
            ev_txf  <= is_last;
            ev_txb  <= !is_last;
            ev_babt <= over_q;
            fill    <= is_last ? '0 : fill_add(fill, tk_q);
            cur_ptr <= w0[WRAP_BIT] ? base_q : cur_ptr + ADDR_W'(DESC_BYTES);
            if (final_slot) begin
              state     <= S_IDLE;
              tx_active <= 1'b0;
            end else begin
              state <= S_D0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 1024,
  localparam int CNT_W   = $clog2(MAX_DESC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              kick,
  input logic              tx_active,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic [ADDR_W-1:0] ring_base,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [31:0]       mem_wdata,
  input logic              fb_valid,
  input logic              ev_txb,
  input logic              ev_txf,
  input logic              ev_babt,
  input logic [CNT_W-1:0]  desc_cnt
);
  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> !mem_wr);
  // R5
  wb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !mem_wdata[31]);
  // R5
  ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ev_txb, ev_txf}));
  // R4
  babt_done_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_babt |-> (ev_txb || ev_txf));
  // R3
  byte_walk_chk: assert property (@(posedge clk) disable iff (!rst_n) fb_valid |-> $past(tx_active));
  // R1
  kick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && ctrl_en && !tx_active) |=> tx_active);
  // R8
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (!tx_active && cur_ptr == ring_base));
  // R7
  desc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) desc_cnt <= CNT_W'(MAX_DESC));
endmodule

bind txr_engine txr_engine_chk #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .kick(kick), .tx_active(tx_active),
  .cur_ptr(cur_ptr), .ring_base(base_q), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .fb_valid(fb_valid), .ev_txb(ev_txb), .ev_txf(ev_txf),
  .ev_babt(ev_babt), .desc_cnt(desc_cnt)
);

// File: tb/txr_engine_test.sv
module txr_engine_test;
  localparam int MAXF = 40;
  localparam int MAXD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_en = 1'b0, enh_mode = 1'b1, base_wr = 1'b0, kick = 1'b0;
  logic [31:0] base_wdata = '0;
  logic tx_active, mem_rd, mem_wr, fb_valid, ev_txb, ev_txf, ev_babt;
  logic [31:0] cur_ptr, mem_addr, mem_wdata, mem_rdata;
  logic [7:0] fb_data;

  always #10 clk = ~clk;

  txr_engine #(.ADDR_W(32), .MAX_FRAME(MAXF), .MAX_DESC(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .enh_mode(enh_mode),
    .base_wr(base_wr), .base_wdata(base_wdata), .kick(kick),
    .tx_active(tx_active), .cur_ptr(cur_ptr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fb_valid(fb_valid), .fb_data(fb_data), .ev_txb(ev_txb), .ev_txf(ev_txf),
    .ev_babt(ev_babt)
  );

  logic [31:0] mem [512];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[10:2]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[10:2]];
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit discard = 1'b0;
  int n_txb = 0, n_txf = 0, n_babt = 0, fcount = 0;
  logic [7:0] exp_bytes [$];
  int exp_lens [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] len, input int b);
    mem[a >> 2]       = {fl, len};
    mem[(a >> 2) + 1] = 32'(b);
  endtask

  task automatic want(input int b, input int len);
    for (int i = 0; i < len; i++) exp_bytes.push_back(pat(b + i));
  endtask

  task automatic want_frame(input int len);
    exp_lens.push_back(len);
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_wdata = v; base_wr = 1'b1;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic wait_idle();
    while (tx_active) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_cnt();
    n_txb = 0; n_txf = 0; n_babt = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ctrl_en) fcount = 0;
      if (fb_valid && !discard) begin
        if (exp_bytes.size() == 0) chk(1'b0, "R3 unexpected byte", fb_data, 0);
        else begin
          logic [7:0] e;
          e = exp_bytes.pop_front();
          chk(fb_data == e, "R3 byte value", fb_data, e);
        end
        fcount++;
      end
      if (ev_txb) n_txb++;
      if (ev_txf) n_txf++;
      if (ev_babt) n_babt++;
      if (ev_txf && !discard) begin
        if (exp_lens.size() == 0) chk(1'b0, "R3 unexpected frame end", fcount, 0);
        else begin
          int el;
          el = exp_lens.pop_front();
          chk(fcount == el, "R3 R4 frame length", fcount, el);
        end
        fcount = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 512; w++) mem[w] = '0;
    for (int w = 128; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_active == 1'b0, "reset tx_active", tx_active, 0);
    chk(cur_ptr == 0, "reset cur_ptr", cur_ptr, 0);
    chk(!fb_valid && !ev_txb && !ev_txf && !ev_babt, "reset outputs", fb_valid, 0);

    // R9 alignment masks
    enh_mode = 1'b1; set_base(32'h107); @(negedge clk);
    chk(cur_ptr == 32'h100, "R9 enhanced mask", cur_ptr, 32'h100);
    enh_mode = 1'b0; set_base(32'h10E); @(negedge clk);
    chk(cur_ptr == 32'h10C, "R9 legacy mask", cur_ptr, 32'h10C);
    enh_mode = 1'b1; set_base(32'h100);

    // ring for first walk
    put_desc(32'h100, 16'h8000, 16'd3, 32'h200);
    put_desc(32'h108, 16'h8800, 16'd2, 32'h301);
    put_desc(32'h110, 16'hA800, 16'd4, 32'h213);

    // R1 kick ignored while disabled
    pulse_kick(); repeat (4) @(negedge clk);
    chk(tx_active == 1'b0, "R1 kick while disabled", tx_active, 0);
    chk(mem[32'h100 >> 2] == 32'h8000_0003, "R1 descriptor untouched", mem[32'h100 >> 2], 32'h8000_0003);

    // R2 R3 R5 R6 gather, writeback, wrap, stop
    ctrl_en = 1'b1; clr_cnt();
    want(32'h200, 3); want(32'h301, 2); want_frame(5);
    want(32'h213, 4); want_frame(4);
    pulse_kick();
    chk(tx_active == 1'b1, "R1 walk started", tx_active, 1);
    wait_idle();
    chk(n_txb == 1, "R5 txb count", n_txb, 1);
    chk(n_txf == 2, "R5 txf count", n_txf, 2);
    chk(n_babt == 0, "R4 no babt", n_babt, 0);
    chk(mem[32'h100 >> 2] == 32'h0000_0003, "R5 writeback d0", mem[32'h100 >> 2], 32'h3);
    chk(mem[32'h110 >> 2] == 32'h2800_0004, "R5 writeback d2", mem[32'h110 >> 2], 32'h2800_0004);
    chk(cur_ptr == 32'h100, "R6 R2 wrap then stop", cur_ptr, 32'h100);

    // R4 truncation
    set_base(32'h140); clr_cnt();
    put_desc(32'h140, 16'h8000, 16'd30, 32'h220);
    put_desc(32'h148, 16'h8800, 16'd20, 32'h260);
    want(32'h220, 30); want(32'h260, 10); want_frame(MAXF);
    pulse_kick(); wait_idle();
    chk(n_babt == 1, "R4 babt pulse", n_babt, 1);
    chk(n_txf == 1 && n_txb == 1, "R4 events", n_txf, 1);
    chk(cur_ptr == 32'h150, "R2 stop pointer", cur_ptr, 32'h150);

    // R7 cap, R1 kick mid-walk ignored
    set_base(32'h180); clr_cnt();
    for (int i = 0; i < 8; i++) put_desc(32'h180 + 8*i, 16'h8800, 16'd1, 32'h300 + i);
    for (int i = 0; i < MAXD; i++) begin want(32'h300 + i, 1); want_frame(1); end
    pulse_kick(); repeat (8) @(negedge clk);
    pulse_kick(); wait_idle();
    chk(n_txf == MAXD, "R7 frames per kick", n_txf, MAXD);
    chk(cur_ptr == 32'h180 + 8*MAXD, "R7 R1 cap pointer", cur_ptr, 32'h180 + 8*MAXD);
    chk(mem[(32'h180 + 8*MAXD) >> 2][31] == 1'b1, "R7 next left ready", mem[(32'h180 + 8*MAXD) >> 2], 32'h8800_0001);

    // R8 disable mid-walk
    set_base(32'h1C0); clr_cnt();
    put_desc(32'h1C0, 16'h8800, 16'd2, 32'h330);
    put_desc(32'h1C8, 16'h8800, 16'd30, 32'h340);
    discard = 1'b1;
    pulse_kick(); repeat (25) @(negedge clk);
    ctrl_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_active == 1'b0, "R8 active cleared", tx_active, 0);
    chk(cur_ptr == 32'h1C0, "R8 pointer reload", cur_ptr, 32'h1C0);
    chk(mem[32'h1C8 >> 2] == 32'h8800_001E, "R8 no writeback", mem[32'h1C8 >> 2], 32'h8800_001E);
    discard = 1'b0; ctrl_en = 1'b1; clr_cnt();
    put_desc(32'h1C0, 16'h8800, 16'd2, 32'h330);
    want(32'h330, 2); want_frame(2); want(32'h340, 30); want_frame(30);
    @(negedge clk);
    pulse_kick(); wait_idle();
    chk(n_txf == 2, "R8 resumed frames", n_txf, 2);
    chk(cur_ptr == 32'h1D0, "R6 linear advance", cur_ptr, 32'h1D0);

    chk(exp_bytes.size() == 0, "R3 all bytes seen", exp_bytes.size(), 0);
    chk(exp_lens.size() == 0, "R3 all frames seen", exp_lens.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule